// File: doc/BRIEF.md
# Transmit Clock Source Selector

This block chooses the clock that drives the transmit side of a T1/E1 line interface. Three candidate sources enter it: a dedicated transmit clock, the clock recovered from the receive line, and a scaled master clock. A two-bit mode field selects among them. In one mode the block watches the dedicated transmit clock and falls back to the receive clock when that clock stops toggling for one channel time. It returns to the transmit clock once that clock has toggled steadily for a full channel time again.

The three candidate clocks are modelled as levels sampled on a free-running reference clock. The selection is a registered source code that steers a combinational multiplexer. The dedicated transmit clock passes through a two-flop synchronizer before an edge detector feeds an inactivity timer. A loss-of-transmit-clock flag is raised while the failover is in force. A shared status output carries either that flag or an external receive loss-of-sync flag, chosen by a routing bit.

The controller has six named states:
- `ST_TX_FIXED`: mode 00.
- `ST_TX_WATCH`: mode 01, running on the transmit clock.
- `ST_RX_FAILOVER`: mode 01, transmit clock lost.
- `ST_RX_RECOVER`: mode 01, transmit clock seen again and being proven.
- `ST_MC_FIXED`: mode 10.
- `ST_RX_FIXED`: mode 11.

A change of mode moves the controller to the entry state of the new mode on the next reference edge. Mode 01 enters at `ST_TX_WATCH`. Inside mode 01 the transitions are:
- `ST_TX_WATCH` goes to `ST_RX_FAILOVER` on timeout.
- `ST_RX_FAILOVER` goes to `ST_RX_RECOVER` on a detected edge.
- `ST_RX_RECOVER` goes back to `ST_RX_FAILOVER` on timeout. This has priority.
- `ST_RX_RECOVER` goes to `ST_TX_WATCH` after CHAN_CYC cycles without timeout.

Top module: `txclk_src_sel`

## Requirements
- R1: After reset `src_sel` is 00 (transmit clock), `tx_clk_loss` is 0, and `status_out` follows `rx_sync_loss`.
- R2: With `mode` = 00, `tx_clk_out` follows `tclk_in` and the block never fails over, even when `tclk_in` stops.
- R3: With `mode` = 10, `src_sel` is 10 and `tx_clk_out` follows `mclk_in`, whatever `tclk_in` does.
- R4: With `mode` = 11, `src_sel` is 01 and `tx_clk_out` follows `rclk_in`, whatever `tclk_in` does.
- R5: With `mode` = 01 and `tclk_in` changing at least every 6 reference cycles, the source stays at 00 and `tx_clk_loss` stays 0.
- R6: With `mode` = 01, once `tclk_in` stops changing the block switches within 16 reference cycles. After the switch `src_sel` is 01, `tx_clk_loss` is 1 and `tx_clk_out` follows `rclk_in`. The timeout is CHAN_CYC (8) reference cycles without a synchronized edge.
- R7: In mode 01 after failover, when `tclk_in` toggles every 2 reference cycles, the block returns within 30 cycles to `src_sel` 00 with `tx_clk_loss` 0.
- R8: `status_out` equals `tx_clk_loss` when `status_sel` is 1 and `rx_sync_loss` when `status_sel` is 0.
- R9: In modes 00, 10 and 11, `tx_clk_loss` is 0. Leaving mode 01 while failed over clears it on the next reference edge.
- R10: After failover, a single transition of `tclk_in` followed by silence does not restore the transmit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for sampling and timing |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Source mode: 00 transmit, 01 transmit with failover, 10 master, 11 receive |
| status_sel | input | 1 | Routing of the shared status output: 0 sync loss, 1 clock loss |
| tclk_in | input | 1 | Dedicated transmit clock level (asynchronous) |
| rclk_in | input | 1 | Recovered receive clock level |
| mclk_in | input | 1 | Scaled master clock level |
| rx_sync_loss | input | 1 | Receive loss-of-sync flag from the framer |
| tx_clk_out | output | 1 | Selected transmit clock |
| src_sel | output | 2 | Current source: 00 transmit, 01 receive, 10 master |
| tx_clk_loss | output | 1 | Loss of transmit clock while failed over |
| status_out | output | 1 | Shared status output |

## Verification
The watched mode is driven with a transmit clock that toggles with gaps just under the timeout, a clock that stops outright, a single isolated transition after failure, and a steady fast toggle. Together these separate a correct inactivity window from one that is too short, a missing failover, a recovery that trusts one edge, and a recovery that never comes. Random levels on all three sources under the fixed modes, mixed with random mode changes, show which input the multiplexer actually steers. Flipping the routing bit while failed over shows that the shared output carries the right flag.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

    typedef enum logic [2:0] {
        ST_TX_FIXED    = 3'd0,
        ST_TX_WATCH    = 3'd1,
        ST_RX_FAILOVER = 3'd2,
        ST_RX_RECOVER  = 3'd3,
        ST_MC_FIXED    = 3'd4,
        ST_RX_FIXED    = 3'd5
    } txcs_state_t;

    typedef enum logic [1:0] {
        SRC_TX = 2'b00,
        SRC_RX = 2'b01,
        SRC_MC = 2'b10
    } txcs_src_t;

    localparam logic [1:0] MODE_TX_ONLY = 2'b00;
    localparam logic [1:0] MODE_TX_AUTO = 2'b01;
    localparam logic [1:0] MODE_MC      = 2'b10;
    localparam logic [1:0] MODE_RX      = 2'b11;

endpackage

// File: rtl/txcs_sync_edge.sv
module txcs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_pulse
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign edge_pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/txcs_idle_timer.sv
module txcs_idle_timer #(
    parameter int CHAN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_pulse,
    output logic timeout
);
    localparam int CW = $clog2(CHAN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CHAN_CYC - 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (edge_pulse) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // CHAN_CYC consecutive cycles without a synchronized edge
    assign timeout = (idle_cnt == LAST) && !edge_pulse;
endmodule

// File: rtl/txcs_fsm.sv
module txcs_fsm
    import txcs_pkg::*;
#(
    parameter int CHAN_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       edge_pulse,
    input  logic       timeout,
    output logic [1:0] src_sel,
    output logic       loss
);
    localparam int CW = $clog2(CHAN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CHAN_CYC - 1);

    txcs_state_t state, state_nx;
    logic [CW-1:0] rec_cnt;

    function automatic txcs_state_t entry_of(input logic [1:0] m);
        unique case (m)
            MODE_TX_ONLY: entry_of = ST_TX_FIXED;
            MODE_TX_AUTO: entry_of = ST_TX_WATCH;
            MODE_MC:      entry_of = ST_MC_FIXED;
            default:      entry_of = ST_RX_FIXED;
        endcase
    endfunction

    function automatic logic in_auto(input txcs_state_t s);
        in_auto = (s == ST_TX_WATCH) || (s == ST_RX_FAILOVER) ||
                  (s == ST_RX_RECOVER);
    endfunction

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_TX_FIXED, ST_MC_FIXED, ST_RX_FIXED: begin
                state_nx = entry_of(mode);
            end
            ST_TX_WATCH: begin
                if (mode != MODE_TX_AUTO) state_nx = entry_of(mode);
                else if (timeout)         state_nx = ST_RX_FAILOVER;
            end
            ST_RX_FAILOVER: begin
                if (mode != MODE_TX_AUTO) state_nx = entry_of(mode);
                else if (edge_pulse)      state_nx = ST_RX_RECOVER;
            end
            ST_RX_RECOVER: begin
                if (mode != MODE_TX_AUTO) state_nx = entry_of(mode);
                else if (timeout)         state_nx = ST_RX_FAILOVER;
                else if (rec_cnt == LAST) state_nx = ST_TX_WATCH;
            end
            default: state_nx = ST_TX_FIXED;
        endcase
    end

    // state register and recovery counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_TX_FIXED;
            rec_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RX_RECOVER && state_nx == ST_RX_RECOVER)
                rec_cnt <= rec_cnt + 1'b1;
            else
                rec_cnt <= '0;
        end
    end

    // outputs from state
    always_comb begin
        src_sel = SRC_TX;
        loss    = 1'b0;
        unique case (state)
            ST_TX_FIXED, ST_TX_WATCH: src_sel = SRC_TX;
            ST_RX_FAILOVER, ST_RX_RECOVER: begin
                src_sel = SRC_RX;
                loss    = in_auto(state);
            end
            ST_MC_FIXED: src_sel = SRC_MC;
            ST_RX_FIXED: src_sel = SRC_RX;
            default:     src_sel = SRC_TX;
        endcase
    end
endmodule

// File: rtl/txclk_src_sel.sv
module txclk_src_sel
    import txcs_pkg::*;
#(
    parameter int CHAN_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       status_sel,
    input  logic       tclk_in,
    input  logic       rclk_in,
    input  logic       mclk_in,
    input  logic       rx_sync_loss,
    output logic       tx_clk_out,
    output logic [1:0] src_sel,
    output logic       tx_clk_loss,
    output logic       status_out
);
    logic tclk_edge;
    logic tclk_timeout;

    txcs_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (tclk_in),
        .edge_pulse (tclk_edge)
    );

    txcs_idle_timer #(.CHAN_CYC(CHAN_CYC)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_pulse (tclk_edge),
        .timeout    (tclk_timeout)
    );

    txcs_fsm #(.CHAN_CYC(CHAN_CYC)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .edge_pulse (tclk_edge),
        .timeout    (tclk_timeout),
        .src_sel    (src_sel),
        .loss       (tx_clk_loss)
    );

    always_comb begin
        unique case (src_sel)
            SRC_RX:  tx_clk_out = rclk_in;
            SRC_MC:  tx_clk_out = mclk_in;
            default: tx_clk_out = tclk_in;
        endcase
    end

    assign status_out = status_sel ? tx_clk_loss : rx_sync_loss;
endmodule

// File: rtl/txcs_checker.sv
module txcs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [1:0] src_sel,
    input logic       tx_clk_loss
);
    AST_RESET_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (src_sel == 2'b00 && !tx_clk_loss)); // R1
    AST_TX_ONLY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (src_sel == 2'b00)); // R2
    AST_MC_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (src_sel == 2'b10)); // R3
    AST_RX_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (src_sel == 2'b01)); // R4
    AST_LOSS_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_loss |-> (src_sel == 2'b01)); // R6
    AST_FIXED_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b01) |=> !tx_clk_loss); // R9
endmodule

bind txclk_src_sel txcs_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .src_sel     (src_sel),
    .tx_clk_loss (tx_clk_loss)
);

// File: tb/txclk_src_sel_tb_top.sv
`timescale 1ns/1ps
module txclk_src_sel_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       status_sel = 1'b0;
    logic       tclk_in = 1'b0;
    logic       rclk_in = 1'b0;
    logic       mclk_in = 1'b0;
    logic       rx_sync_loss = 1'b0;
    logic       tx_clk_out;
    logic [1:0] src_sel;
    logic       tx_clk_loss;
    logic       status_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    txclk_src_sel dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .status_sel(status_sel),
        .tclk_in(tclk_in), .rclk_in(rclk_in), .mclk_in(mclk_in),
        .rx_sync_loss(rx_sync_loss), .tx_clk_out(tx_clk_out),
        .src_sel(src_sel), .tx_clk_loss(tx_clk_loss), .status_out(status_out)
    );

    function automatic logic exp_out(input logic [1:0] m, input logic t,
                                     input logic r, input logic mc);
        case (m)
            2'b10:   exp_out = mc;
            2'b11:   exp_out = r;
            default: exp_out = t;
        endcase
    endfunction

    function automatic logic [1:0] exp_src(input logic [1:0] m);
        case (m)
            2'b10:   exp_src = 2'b10;
            2'b11:   exp_src = 2'b01;
            default: exp_src = 2'b00;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #1600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        rx_sync_loss = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 src", src_sel, 0);
        chk("R1 loss", tx_clk_loss, 0);
        chk("R1 status", status_out, 1);
        rx_sync_loss = 1'b0; #1;
        chk("R1 status low", status_out, 0);

        // R2 mode 00 follows tclk, never fails over
        for (int i = 0; i < 6; i++) begin
            tclk_in = ~tclk_in; rclk_in = tclk_in; mclk_in = tclk_in; #1;
            rclk_in = ~tclk_in; mclk_in = ~tclk_in; #1;
            chk("R2 follow", tx_clk_out, tclk_in);
            cyc(1);
        end
        cyc(20);
        chk("R2 no failover src", src_sel, 0);
        chk("R2 no failover loss", tx_clk_loss, 0);

        // R3 master clock
        mode = 2'b10; cyc(2);
        chk("R3 src", src_sel, 2);
        for (int i = 0; i < 4; i++) begin
            mclk_in = i[0]; tclk_in = ~i[0]; rclk_in = ~i[0]; #1;
            chk("R3 follow", tx_clk_out, mclk_in);
        end
        // R4 receive clock
        mode = 2'b11; cyc(2);
        chk("R4 src", src_sel, 1);
        chk("R4 loss", tx_clk_loss, 0);
        for (int i = 0; i < 4; i++) begin
            rclk_in = i[0]; tclk_in = ~i[0]; mclk_in = ~i[0]; #1;
            chk("R4 follow", tx_clk_out, rclk_in);
        end

        // R5 watched mode with gaps of 6 cycles
        mode = 2'b00;
        for (int i = 0; i < 4; i++) begin tclk_in = ~tclk_in; cyc(1); end
        mode = 2'b01;
        for (int i = 0; i < 60; i++) begin
            if (i % 6 == 0) tclk_in = ~tclk_in;
            cyc(1);
            if (src_sel != 2'b00 || tx_clk_loss) chk("R5 hold", {src_sel, tx_clk_loss}, 0);
        end
        chk("R5 src", src_sel, 0);
        chk("R5 loss", tx_clk_loss, 0);

        // R6 stop -> failover
        cyc(16);
        chk("R6 src", src_sel, 1);
        chk("R6 loss", tx_clk_loss, 1);
        rclk_in = 1'b1; tclk_in = tclk_in; #1;
        chk("R6 follow rclk", tx_clk_out, 1);
        rclk_in = 1'b0; #1;
        chk("R6 follow rclk low", tx_clk_out, 0);

        // R8 status routing
        rx_sync_loss = 1'b0; status_sel = 1'b1; #1;
        chk("R8 loss routed", status_out, 1);
        status_sel = 1'b0; rx_sync_loss = 1'b1; #1;
        chk("R8 sync routed", status_out, 1);
        rx_sync_loss = 1'b0; #1;
        chk("R8 sync routed low", status_out, 0);

        // R10 single transition does not restore
        tclk_in = ~tclk_in;
        cyc(24);
        chk("R10 src", src_sel, 1);
        chk("R10 loss", tx_clk_loss, 1);

        // R7 steady toggle restores
        for (int i = 0; i < 30; i++) begin
            if (i % 2 == 0) tclk_in = ~tclk_in;
            cyc(1);
        end
        chk("R7 src", src_sel, 0);
        chk("R7 loss", tx_clk_loss, 0);

        // R9 leaving mode 01 while failed clears the flag next edge
        cyc(16);
        chk("R9 pre loss", tx_clk_loss, 1);
        status_sel = 1'b1;
        mode = 2'b00; cyc(1);
        chk("R9 loss cleared", tx_clk_loss, 0);
        chk("R9 src", src_sel, 0);
        chk("R9 status", status_out, 0);
        status_sel = 1'b0;

        // random fixed modes R2 R3 R4 R9
        for (int i = 0; i < 300; i++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 2));
            if (m == 2'b01) m = 2'b11;
            mode = m;
            cyc(1);
            tclk_in = 1'($urandom); rclk_in = 1'($urandom); mclk_in = 1'($urandom); #1;
            if (tx_clk_out != exp_out(m, tclk_in, rclk_in, mclk_in))
                chk("R2/R3/R4 random out", tx_clk_out, exp_out(m, tclk_in, rclk_in, mclk_in));
            else checks++;
            if (src_sel != exp_src(m)) chk("R3/R4 random src", src_sel, exp_src(m));
            if (tx_clk_loss) chk("R9 random loss", tx_clk_loss, 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule